// File: doc/BRIEF.md
# Trap-Return State Restore Unit

This block carries out the state update of a machine-mode trap return for a small core with level-based interrupts. On a return strobe it takes the saved exception PC, the saved privilege, the saved interrupt enable and the saved interrupt level. It produces the next PC, the new privilege mode, the new enable pair and the new active interrupt level. When the return goes back to user mode, it also clears the interrupt threshold.

The return can also be vectored. This happens when the inhibit-vector flag is set and the saved privilege is not user. In that case the unit fetches one pointer word from the word-aligned exception PC and jumps to that word with bit 0 cleared. A bus error on that fetch turns the return into an instruction access fault, and the architectural state is left untouched.

The unit also owns the active interrupt level. Interrupt takes and writes through the next-interrupt CSR can change it. Each such write is screened against the threshold and the saved level before it is applied.

Top module: `trap_return_unit`

## Requirements
- R1: A return strobe accepted while idle is non-vectored when the inhibit flag is 0 or the saved privilege is user (00). In that case done_o is high for exactly the next cycle, and pc_o then equals the epc_i value sampled with the strobe.
- R2: A vectored return (inhibit flag 1 and saved privilege not 00) raises fetch_req_o the cycle after the strobe. The fetch address is epc_i with bits 1:0 forced to 0. The request is held until fetch_ack_i. done_o rises in the cycle after the accepted response, and pc_o is then the returned word with bit 0 cleared.
- R3: After a successful return, mode_o equals the saved privilege (user 00, supervisor 01, machine 11).
- R4: After a successful return, mie_o equals the saved enable and mpie_o is 1.
- R5: After a successful return, mil_o equals the saved level.
- R6: A successful return to user mode clears thresh_o to 0. Any other return keeps it. A threshold write loads thr_wdata_i in the next cycle.
- R7: An error response on the pointer fetch gives one cycle with done_o and fault_o both high. pc_o, mode_o, mie_o, mpie_o, mil_o and thresh_o stay unchanged.
- R8: On a vectored return, the saved privilege, enable and level are captured with the strobe. Changes on those inputs during the fetch have no effect on the result.
- R9: No fetch request is made without an accepted strobe. A strobe that arrives while a fetch is in flight is ignored: only one done pulse follows, and no second request is made.
- R10: An interrupt take loads take_lvl_i into mil_o in the next cycle.
- R11: A next-interrupt write that raises the level is applied only when the current level is 0 or the new level is at least thresh_o. Otherwise mil_o is unchanged.
- R12: A next-interrupt write that lowers the level is applied only when the new level is above the larger of thresh_o and pil_i. Otherwise mil_o is unchanged.
- R13: Reset sets pc_o to 0, mode_o to 11, mie_o, mpie_o, mil_o and thresh_o to 0, and done_o, fault_o and fetch_req_o low.
- R14: When several level updates meet at one edge, the return restore takes priority over an interrupt take, and an interrupt take takes priority over a next-interrupt write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_i | input | 1 | Return strobe |
| epc_i | input | XLEN | Saved exception PC |
| pp_i | input | 2 | Saved privilege |
| pie_i | input | 1 | Saved interrupt enable |
| pil_i | input | LVL_W | Saved interrupt level |
| inhv_i | input | 1 | Inhibit-vector flag |
| thr_we_i | input | 1 | Threshold write enable |
| thr_wdata_i | input | LVL_W | Threshold write value |
| take_i | input | 1 | Interrupt taken |
| take_lvl_i | input | LVL_W | Level of taken interrupt |
| nxti_we_i | input | 1 | Next-interrupt CSR level write |
| nxti_lvl_i | input | LVL_W | Level requested by that write |
| fetch_req_o | output | 1 | Pointer fetch request |
| fetch_addr_o | output | XLEN | Pointer fetch address |
| fetch_ack_i | input | 1 | Fetch response valid |
| fetch_err_i | input | 1 | Fetch response error |
| fetch_data_i | input | XLEN | Fetch response word |
| pc_o | output | XLEN | Next PC |
| mode_o | output | 2 | Privilege mode |
| mie_o | output | 1 | Interrupt enable |
| mpie_o | output | 1 | Previous interrupt enable |
| mil_o | output | LVL_W | Active interrupt level |
| thresh_o | output | LVL_W | Interrupt threshold |
| done_o | output | 1 | Return complete pulse |
| fault_o | output | 1 | Instruction access fault pulse |

## Verification
The assertions assume the following about the inputs:
- fetch_ack_i arrives only while a request is pending.
- The strobe carries a saved privilege of 00, 01 or 11.
- An interrupt take is legal as issued by the arbiter, which is why the level checks leave take cycles out.

The stimulus stays within these limits. Its memory responder answers only while fetch_req_o is high, after a programmable wait of zero to two cycles. Return sweeps use only the three legal privilege codes. Level sweeps set the start level through a take and then probe raising, lowering and equal next-interrupt writes against several thresholds and saved levels.

// File: rtl/tru_pkg.sv
package tru_pkg;
  typedef enum logic [1:0] {
    PRV_U = 2'b00,
    PRV_S = 2'b01,
    PRV_M = 2'b11
  } prv_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_WAIT = 1'b1
  } fetch_st_e;
endpackage

// File: rtl/tru_fetch.sv
module tru_fetch
  import tru_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic            ack_i,
  input  logic            err_i,
  input  logic [XLEN-1:0] data_i,
  output logic            req_o,
  output logic [XLEN-1:0] addr_o,
  output logic            busy_o,
  output logic            ok_o,
  output logic            err_o,
  output logic [XLEN-1:0] tgt_o
);
  localparam logic [XLEN-1:0] WORD_MASK = ~(XLEN'(3));
  localparam logic [XLEN-1:0] LSB_MASK  = ~(XLEN'(1));

  fetch_st_e       st_q;
  logic [XLEN-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (start_i) begin
          st_q   <= FS_WAIT;
          addr_q <= addr_i & WORD_MASK;
        end
        FS_WAIT: if (ack_i) st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == FS_WAIT);
  assign req_o  = busy_o;
  assign addr_o = addr_q;
  assign ok_o   = busy_o && ack_i && !err_i;
  assign err_o  = busy_o && ack_i && err_i;
  assign tgt_o  = data_i & LSB_MASK;
endmodule

// File: rtl/tru_level.sv
module tru_level #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restore_i,
  input  logic [LVL_W-1:0] restore_lvl_i,
  input  logic             take_i,
  input  logic [LVL_W-1:0] take_lvl_i,
  input  logic             nxti_we_i,
  input  logic [LVL_W-1:0] nxti_lvl_i,
  input  logic [LVL_W-1:0] thresh_i,
  input  logic [LVL_W-1:0] pil_i,
  output logic [LVL_W-1:0] lvl_o
);
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] floor_lvl;
  logic             nxti_ok;

  // screen next-interrupt writes: raise needs threshold, lower must stay above floor
  always_comb begin
    floor_lvl = (thresh_i > pil_i) ? thresh_i : pil_i;
    if (nxti_lvl_i > lvl_q)      nxti_ok = (lvl_q == '0) || (nxti_lvl_i >= thresh_i);
    else if (nxti_lvl_i < lvl_q) nxti_ok = (nxti_lvl_i > floor_lvl);
    else                         nxti_ok = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    lvl_q <= '0;
    else if (restore_i)             lvl_q <= restore_lvl_i;
    else if (take_i)                lvl_q <= take_lvl_i;
    else if (nxti_we_i && nxti_ok)  lvl_q <= nxti_lvl_i;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import tru_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ret_i,
  input  logic [XLEN-1:0]  epc_i,
  input  logic [1:0]       pp_i,
  input  logic             pie_i,
  input  logic [LVL_W-1:0] pil_i,
  input  logic             inhv_i,
  input  logic             thr_we_i,
  input  logic [LVL_W-1:0] thr_wdata_i,
  input  logic             take_i,
  input  logic [LVL_W-1:0] take_lvl_i,
  input  logic             nxti_we_i,
  input  logic [LVL_W-1:0] nxti_lvl_i,
  output logic             fetch_req_o,
  output logic [XLEN-1:0]  fetch_addr_o,
  input  logic             fetch_ack_i,
  input  logic             fetch_err_i,
  input  logic [XLEN-1:0]  fetch_data_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [1:0]       mode_o,
  output logic             mie_o,
  output logic             mpie_o,
  output logic [LVL_W-1:0] mil_o,
  output logic [LVL_W-1:0] thresh_o,
  output logic             done_o,
  output logic             fault_o
);
  logic             busy, f_ok, f_err;
  logic [XLEN-1:0]  f_tgt;
  logic             vec_sel, vec_start, plain_ret, restore;

  prv_e             sv_pp_q;
  logic             sv_pie_q;
  logic [LVL_W-1:0] sv_pil_q;

  prv_e             rs_pp;
  logic             rs_pie;
  logic [LVL_W-1:0] rs_pil;
  logic [XLEN-1:0]  rs_pc;

  logic [XLEN-1:0]  pc_q;
  prv_e             mode_q;
  logic             mie_q, mpie_q, done_q, fault_q;
  logic [LVL_W-1:0] thr_q;

  assign vec_sel   = inhv_i && (prv_e'(pp_i) != PRV_U);
  assign vec_start = ret_i && !busy && vec_sel;
  assign plain_ret = ret_i && !busy && !vec_sel;
  assign restore   = plain_ret || f_ok;

  tru_fetch #(.XLEN(XLEN)) u_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (vec_start),
    .addr_i  (epc_i),
    .ack_i   (fetch_ack_i),
    .err_i   (fetch_err_i),
    .data_i  (fetch_data_i),
    .req_o   (fetch_req_o),
    .addr_o  (fetch_addr_o),
    .busy_o  (busy),
    .ok_o    (f_ok),
    .err_o   (f_err),
    .tgt_o   (f_tgt)
  );

  // saved fields frozen at strobe so CSR writes during the fetch cannot leak in
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sv_pp_q  <= PRV_M;
      sv_pie_q <= 1'b0;
      sv_pil_q <= '0;
    end else if (vec_start) begin
      sv_pp_q  <= prv_e'(pp_i);
      sv_pie_q <= pie_i;
      sv_pil_q <= pil_i;
    end
  end

  always_comb begin
    if (plain_ret) begin
      rs_pp  = prv_e'(pp_i);
      rs_pie = pie_i;
      rs_pil = pil_i;
      rs_pc  = epc_i;
    end else begin
      rs_pp  = sv_pp_q;
      rs_pie = sv_pie_q;
      rs_pil = sv_pil_q;
      rs_pc  = f_tgt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      mode_q  <= PRV_M;
      mie_q   <= 1'b0;
      mpie_q  <= 1'b0;
      thr_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= restore || f_err;
      fault_q <= f_err;
      if (restore) begin
        pc_q   <= rs_pc;
        mode_q <= rs_pp;
        mie_q  <= rs_pie;
        mpie_q <= 1'b1;
      end
      if (restore && rs_pp == PRV_U) thr_q <= '0;
      else if (thr_we_i)             thr_q <= thr_wdata_i;
    end
  end

  tru_level #(.LVL_W(LVL_W)) u_level (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .restore_i     (restore),
    .restore_lvl_i (rs_pil),
    .take_i        (take_i),
    .take_lvl_i    (take_lvl_i),
    .nxti_we_i     (nxti_we_i),
    .nxti_lvl_i    (nxti_lvl_i),
    .thresh_i      (thr_q),
    .pil_i         (pil_i),
    .lvl_o         (mil_o)
  );

  assign pc_o     = pc_q;
  assign mode_o   = mode_q;
  assign mie_o    = mie_q;
  assign mpie_o   = mpie_q;
  assign thresh_o = thr_q;
  assign done_o   = done_q;
  assign fault_o  = fault_q;
endmodule

// File: rtl/tru_chk.sv
module tru_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned LVL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ret_i,
  input logic [XLEN-1:0]  epc_i,
  input logic [1:0]       pp_i,
  input logic [LVL_W-1:0] pil_i,
  input logic             inhv_i,
  input logic             take_i,
  input logic             nxti_we_i,
  input logic             fetch_req_o,
  input logic [XLEN-1:0]  fetch_addr_o,
  input logic [XLEN-1:0]  pc_o,
  input logic [1:0]       mode_o,
  input logic             mie_o,
  input logic             mpie_o,
  input logic [LVL_W-1:0] mil_o,
  input logic [LVL_W-1:0] thresh_o,
  input logic             done_o,
  input logic             fault_o
);
  // R9
  req_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fetch_req_o) |-> $past(ret_i));

  // R2
  fetch_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> fetch_addr_o[1:0] == 2'b00);

  // R2
  ptr_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o && $past(fetch_req_o) |-> !pc_o[0]);

  // R1
  plain_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !fetch_req_o && !(inhv_i && pp_i != 2'b00)
    |=> done_o && !fault_o && pc_o == $past(epc_i));

  // R4
  mpie_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o |-> mpie_o);

  // R6
  user_thr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_o && mode_o == 2'b00 |-> thresh_o == '0);

  // R7
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o && $past(fetch_req_o) && $stable(pc_o) && $stable(mode_o)
                && $stable(mie_o) && $stable(mpie_o));

  // R5
  mil_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mil_o != $past(mil_o) |-> done_o || $past(take_i) || $past(nxti_we_i));

  // R11
  nxti_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mil_o > $past(mil_o) && !done_o && !$past(take_i)
    |-> $past(mil_o) == '0 || mil_o >= $past(thresh_o));

  // R12
  nxti_lower_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mil_o < $past(mil_o) && !done_o && !$past(take_i)
    |-> mil_o > (($past(thresh_o) > $past(pil_i)) ? $past(thresh_o) : $past(pil_i)));
endmodule

bind trap_return_unit tru_chk #(.XLEN(XLEN), .LVL_W(LVL_W)) u_tru_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ret_i        (ret_i),
  .epc_i        (epc_i),
  .pp_i         (pp_i),
  .pil_i        (pil_i),
  .inhv_i       (inhv_i),
  .take_i       (take_i),
  .nxti_we_i    (nxti_we_i),
  .fetch_req_o  (fetch_req_o),
  .fetch_addr_o (fetch_addr_o),
  .pc_o         (pc_o),
  .mode_o       (mode_o),
  .mie_o        (mie_o),
  .mpie_o       (mpie_o),
  .mil_o        (mil_o),
  .thresh_o     (thresh_o),
  .done_o       (done_o),
  .fault_o      (fault_o)
);

// File: tb/tb_trap_return_unit.sv
module tb_trap_return_unit;
  localparam int XLEN  = 32;
  localparam int LVL_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_ni;
  logic             ret_i;
  logic [XLEN-1:0]  epc_i;
  logic [1:0]       pp_i;
  logic             pie_i;
  logic [LVL_W-1:0] pil_i;
  logic             inhv_i;
  logic             thr_we_i;
  logic [LVL_W-1:0] thr_wdata_i;
  logic             take_i;
  logic [LVL_W-1:0] take_lvl_i;
  logic             nxti_we_i;
  logic [LVL_W-1:0] nxti_lvl_i;
  logic             fetch_req_o;
  logic [XLEN-1:0]  fetch_addr_o;
  logic             fetch_ack_i;
  logic             fetch_err_i;
  logic [XLEN-1:0]  fetch_data_i;
  logic [XLEN-1:0]  pc_o;
  logic [1:0]       mode_o;
  logic             mie_o, mpie_o;
  logic [LVL_W-1:0] mil_o, thresh_o;
  logic             done_o, fault_o;

  trap_return_unit #(.XLEN(XLEN), .LVL_W(LVL_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ret_i(ret_i), .epc_i(epc_i), .pp_i(pp_i),
    .pie_i(pie_i), .pil_i(pil_i), .inhv_i(inhv_i), .thr_we_i(thr_we_i),
    .thr_wdata_i(thr_wdata_i), .take_i(take_i), .take_lvl_i(take_lvl_i),
    .nxti_we_i(nxti_we_i), .nxti_lvl_i(nxti_lvl_i), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .fetch_ack_i(fetch_ack_i), .fetch_err_i(fetch_err_i),
    .fetch_data_i(fetch_data_i), .pc_o(pc_o), .mode_o(mode_o), .mie_o(mie_o),
    .mpie_o(mpie_o), .mil_o(mil_o), .thresh_o(thresh_o), .done_o(done_o),
    .fault_o(fault_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // expected architectural state
  logic [31:0] e_pc;
  logic [1:0]  e_mode;
  logic        e_mie, e_mpie;
  logic [7:0]  e_mil, e_thr;

  // memory responder
  int   mem_lat = 0;
  logic mem_err = 1'b0;
  int   wcnt = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a ^ 32'hA5C3_0F1E) + 32'h13;
  endfunction

  always @(negedge clk) begin
    if (fetch_req_o) begin
      if (wcnt == mem_lat) begin
        fetch_ack_i  = 1'b1;
        fetch_err_i  = mem_err;
        fetch_data_i = mem_word(fetch_addr_o);
        wcnt = 0;
      end else begin
        fetch_ack_i = 1'b0;
        wcnt++;
      end
    end else begin
      fetch_ack_i = 1'b0;
      wcnt = 0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input bit errcase, input bit vec);
    chk(errcase ? "R7" : (vec ? "R8" : "R1"), "pc",     pc_o,              e_pc);
    chk(errcase ? "R7" : (vec ? "R8" : "R3"), "mode",   32'(mode_o),       32'(e_mode));
    chk(errcase ? "R7" : (vec ? "R8" : "R4"), "mie",    32'(mie_o),        32'(e_mie));
    chk(errcase ? "R7" : "R4",                "mpie",   32'(mpie_o),       32'(e_mpie));
    chk(errcase ? "R7" : (vec ? "R8" : "R5"), "mil",    32'(mil_o),        32'(e_mil));
    chk(errcase ? "R7" : "R6",                "thresh", 32'(thresh_o),     32'(e_thr));
  endtask

  task automatic set_thr(input logic [7:0] v);
    @(negedge clk); thr_we_i = 1'b1; thr_wdata_i = v;
    @(negedge clk); thr_we_i = 1'b0;
    e_thr = v;
    chk("R6", "thr write", 32'(thresh_o), 32'(e_thr));
  endtask

  task automatic take(input logic [7:0] l);
    @(negedge clk); take_i = 1'b1; take_lvl_i = l;
    @(negedge clk); take_i = 1'b0;
    e_mil = l;
    chk("R10", "take level", 32'(mil_o), 32'(e_mil));
  endtask

  function automatic bit nxti_legal(input logic [7:0] cur, input logic [7:0] nw,
                                    input logic [7:0] thr, input logic [7:0] pil);
    if (nw > cur) return (cur == 0) || (nw >= thr);
    if (nw < cur) return nw > ((thr > pil) ? thr : pil);
    return 1'b1;
  endfunction

  task automatic nxti(input logic [7:0] l);
    bit ok;
    ok = nxti_legal(e_mil, l, e_thr, pil_i);
    @(negedge clk); nxti_we_i = 1'b1; nxti_lvl_i = l;
    @(negedge clk); nxti_we_i = 1'b0;
    if (l > e_mil) begin
      if (ok) e_mil = l;
      chk("R11", "nxti raise", 32'(mil_o), 32'(e_mil));
    end else begin
      if (ok) e_mil = l;
      chk("R12", "nxti lower/equal", 32'(mil_o), 32'(e_mil));
    end
  endtask

  task automatic do_ret(input logic [1:0] pp, input logic pie, input logic [7:0] pil,
                        input logic inhv, input logic [31:0] epc, input int lat, input logic err);
    bit vec;
    int cnt;
    vec = inhv && (pp != 2'b00);
    mem_lat = lat;
    mem_err = err;
    @(negedge clk);
    ret_i = 1'b1; epc_i = epc; pp_i = pp; pie_i = pie; pil_i = pil; inhv_i = inhv;
    @(negedge clk);
    ret_i = 1'b0;
    if (!vec) begin
      chk("R1", "done after strobe", 32'(done_o), 32'd1);
      chk("R1", "no fault", 32'(fault_o), 32'd0);
      e_pc = epc; e_mode = pp; e_mie = pie; e_mpie = 1'b1; e_mil = pil;
      if (pp == 2'b00) e_thr = 8'd0;
      chk_state(1'b0, 1'b0);
    end else begin
      chk("R2", "req", 32'(fetch_req_o), 32'd1);
      chk("R2", "addr", fetch_addr_o, epc & ~32'h3);
      chk("R2", "done early", 32'(done_o), 32'd0);
      // R8 scramble saved fields, R9 extra strobe while busy
      pp_i = ~pp; pie_i = ~pie; pil_i = ~pil; ret_i = 1'b1;
      cnt = 1;
      while (!done_o && cnt < 40) begin
        @(negedge clk);
        ret_i = 1'b0;
        cnt++;
      end
      ret_i = 1'b0;
      chk("R2", "latency", 32'(cnt), 32'(lat + 2));
      if (err) begin
        chk("R7", "fault", 32'(fault_o), 32'd1);
      end else begin
        chk("R2", "fault", 32'(fault_o), 32'd0);
        e_pc = mem_word(epc & ~32'h3) & ~32'h1;
        e_mode = pp; e_mie = pie; e_mpie = 1'b1; e_mil = pil;
      end
      chk_state(err, 1'b1);
    end
    @(negedge clk);
    chk("R9", "single done", 32'(done_o), 32'd0);
    chk("R9", "no second req", 32'(fetch_req_o), 32'd0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; ret_i = 0; epc_i = '0; pp_i = '0; pie_i = 0; pil_i = '0; inhv_i = 0;
    thr_we_i = 0; thr_wdata_i = '0; take_i = 0; take_lvl_i = '0; nxti_we_i = 0; nxti_lvl_i = '0;
    fetch_ack_i = 0; fetch_err_i = 0; fetch_data_i = '0;
    e_pc = '0; e_mode = 2'b11; e_mie = 0; e_mpie = 0; e_mil = '0; e_thr = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R13
    chk("R13", "reset pc", pc_o, 32'd0);
    chk("R13", "reset mode", 32'(mode_o), 32'd3);
    chk("R13", "reset mie", 32'(mie_o), 32'd0);
    chk("R13", "reset mpie", 32'(mpie_o), 32'd0);
    chk("R13", "reset mil", 32'(mil_o), 32'd0);
    chk("R13", "reset thresh", 32'(thresh_o), 32'd0);
    chk("R13", "reset done", 32'(done_o), 32'd0);
    chk("R13", "reset fault", 32'(fault_o), 32'd0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9", "idle no req", 32'(fetch_req_o), 32'd0);
    end

    // return sweep
    begin
      int idx;
      idx = 0;
      for (int a = 0; a < 3; a++)
        for (int b = 0; b < 2; b++)
          for (int h = 0; h < 2; h++)
            for (int c = 0; c < 3; c++)
              for (int lat = 0; lat < 3; lat++)
                for (int er = 0; er < 2; er++) begin
                  logic [1:0] pp;
                  logic [7:0] pil;
                  pp  = (a == 2) ? 2'b11 : 2'(a);
                  pil = (c == 0) ? 8'd0 : ((c == 1) ? 8'd5 : 8'd255);
                  if (!(h == 1 && pp != 2'b00) && (lat != 0 || er != 0)) continue;
                  set_thr(8'd7);
                  take(8'd9);
                  do_ret(pp, b[0], pil, h[0], 32'h8000_0103 + 32'(idx * 4), lat, er[0]);
                  idx++;
                end
    end

    // next-interrupt level sweep
    for (int ti = 0; ti < 3; ti++)
      for (int mi = 0; mi < 3; mi++)
        for (int pi = 0; pi < 2; pi++)
          for (int n = 0; n < 13; n++) begin
            set_thr((ti == 0) ? 8'd0 : ((ti == 1) ? 8'd3 : 8'd8));
            take((mi == 0) ? 8'd0 : ((mi == 1) ? 8'd4 : 8'd9));
            pil_i = (pi == 0) ? 8'd0 : 8'd5;
            nxti(8'(n));
          end

    // R14 priority: restore over take over nxti
    @(negedge clk);
    ret_i = 1'b1; epc_i = 32'h0000_4000; pp_i = 2'b11; pie_i = 1'b1; pil_i = 8'd4; inhv_i = 1'b0;
    take_i = 1'b1; take_lvl_i = 8'd20; nxti_we_i = 1'b1; nxti_lvl_i = 8'd30;
    @(negedge clk);
    ret_i = 1'b0; take_i = 1'b0; nxti_we_i = 1'b0;
    chk("R14", "restore wins", 32'(mil_o), 32'd4);
    e_mil = 8'd4;
    @(negedge clk);
    take_i = 1'b1; take_lvl_i = 8'd6; nxti_we_i = 1'b1; nxti_lvl_i = 8'd2;
    @(negedge clk);
    take_i = 1'b0; nxti_we_i = 1'b0;
    chk("R14", "take wins", 32'(mil_o), 32'd6);

    finished = 1;
    summary();
    $finish;
  end
endmodule